// File: doc/BRIEF.md
# FSK Cycle-Count Demodulator

This block turns a stream of 8-bit carrier-envelope samples, one per carrier clock tick, into a stream of half-bit symbols for a downstream frame decoder. Each sample is sliced to a single level. The block then measures the distance between successive rising crossings of the sliced stream and sorts each distance into one of two spacing classes: narrow (a carrier divided by eight) or wide (a carrier divided by ten). Noisy distances are tolerated by a single split point.

Consecutive distances of the same class are merged into a run. When a distance of the other class arrives, the finished run is turned into a number of half-bit times by biased integer division. That many copies of the run's symbol are then presented on the output, one per clock. Samples arrive with a valid strobe and may have gaps. The output is a symbol with its own valid strobe, and that strobe may stay high for several consecutive cycles for one run.

Top module: `fskd_demod`

## Requirements
- R1: A sample is sliced to 1 when its value is 127 or more, and to 0 when it is 126 or less.
- R2: Nothing is produced until the sliced stream has shown a 0 followed by a 1. That first rising crossing only starts the timing and yields no distance.
- R3: A distance is the number of accepted samples from one rising crossing to the next. Cycles with the sample strobe low are not counted. A distance of 8 or less is narrow, and 9 or more is wide.
- R4: Consecutive distances of the same class form one run of length n. The run is closed by the first distance of the other class, which opens a new run of length 1.
- R5: A closed run of length n is worth (n+1)/6 half-bit times when narrow and (n+1)/5 when wide, using integer division that rounds down.
- R6: A worth of 1 to 4 produces that many output symbols on consecutive cycles. The symbol is 1 for a narrow run and 0 for a wide run.
- R7: A worth of 0 or of more than 4 produces no output symbol.
- R8: When the sample that closes a run is accepted at clock edge E, the symbols are valid in the cycles that follow edges E+1 through E+c, where c is the number of copies.
- R9: The distance counter and the run counter are 8 bits wide and saturate at 255 instead of wrapping. A gap of 255 or more samples is therefore wide, and a run of 255 or more is worth more than 4.
- R10: Reset forces the output strobe low at once and clears all state. After reset the block waits for a new first rising crossing, and no run from before the reset is carried over.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| smp_valid | input | 1 | High when smp_data carries a sample |
| smp_data | input | 8 | Envelope sample, unsigned |
| hb_valid | output | 1 | High for each output half-bit symbol |
| hb_value | output | 1 | Half-bit symbol: 1 from a narrow run, 0 from a wide run |

## Verification
The only timed result is the burst of symbols at the close of a run. Copy j of that burst is due in the cycle after edge E+1+j, where E is the edge that accepts the closing sample. The driver records the cycle index at which it presents each sample and runs the model of the requirements on it. It queues every expected symbol together with that due cycle. The monitor samples on the falling clock edge and compares both the symbol and the cycle in which it appeared. An output that arrives when nothing is queued, or that arrives in the wrong cycle, is reported. Each scenario ends with a settle period followed by a check that no expected symbol is left in the queue.

// File: rtl/fskd_pkg.sv
package fskd_pkg;
  // Spacing class of one crossing-to-crossing distance.
  typedef enum logic {
    SPC_WIDE   = 1'b0,
    SPC_NARROW = 1'b1
  } spacing_e;
endpackage

// File: rtl/fskd_edge_timer.sv
module fskd_edge_timer
  import fskd_pkg::*;
#(
  parameter int SAMPLE_W     = 8,
  parameter int SLICE_LEVEL  = 127,
  parameter int PERIOD_W     = 8,
  parameter int NARROW_LIMIT = 9
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                smp_valid,
  input  logic [SAMPLE_W-1:0] smp_data,
  output logic                per_valid,
  output spacing_e            per_class
);
  localparam logic [SAMPLE_W-1:0] LEVEL   = SAMPLE_W'(SLICE_LEVEL);
  localparam logic [PERIOD_W-1:0] NLIM    = PERIOD_W'(NARROW_LIMIT);
  localparam logic [PERIOD_W-1:0] CNT_MAX = '1;
  localparam logic [PERIOD_W-1:0] CNT_ONE = PERIOD_W'(1);

  logic                prev_q, prev_d;
  logic                seen_q, seen_d;
  logic                synced_q, synced_d;
  logic [PERIOD_W-1:0] cnt_q, cnt_d;
  logic                per_valid_q, per_valid_d;
  spacing_e            per_class_q, per_class_d;
  logic                sliced, rising;

  assign sliced = (smp_data >= LEVEL);
  assign rising = seen_q && !prev_q && sliced;

  always_comb begin
    prev_d      = prev_q;
    seen_d      = seen_q;
    synced_d    = synced_q;
    cnt_d       = cnt_q;
    per_valid_d = 1'b0;
    per_class_d = per_class_q;
    if (smp_valid) begin
      prev_d = sliced;
      seen_d = 1'b1;
      if (rising) begin
        if (synced_q) begin
          per_valid_d = 1'b1;
          per_class_d = (cnt_q < NLIM) ? SPC_NARROW : SPC_WIDE;
        end
        cnt_d    = CNT_ONE;
        synced_d = 1'b1;
      end else if (synced_q && (cnt_q != CNT_MAX)) begin
        cnt_d = cnt_q + CNT_ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q      <= 1'b0;
      seen_q      <= 1'b0;
      synced_q    <= 1'b0;
      cnt_q       <= '0;
      per_valid_q <= 1'b0;
      per_class_q <= SPC_WIDE;
    end else begin
      prev_q      <= prev_d;
      seen_q      <= seen_d;
      synced_q    <= synced_d;
      cnt_q       <= cnt_d;
      per_valid_q <= per_valid_d;
      per_class_q <= per_class_d;
    end
  end

  assign per_valid = per_valid_q;
  assign per_class = per_class_q;

  // R3: a missing sample neither advances the count nor yields a distance
  assert_hold_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |=> ($stable(cnt_q) && !per_valid_q));
  // R2: a distance only follows an already recorded first crossing
  assert_sync_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
    per_valid_q |-> $past(synced_q));
  // R9: the saturating count never reaches zero once timing runs
  assert_cnt_nonzero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    synced_q |-> (cnt_q != '0));
endmodule

// File: rtl/fskd_run_grouper.sv
module fskd_run_grouper
  import fskd_pkg::*;
#(
  parameter int RUN_W      = 8,
  parameter int DIV_NARROW = 6,
  parameter int DIV_WIDE   = 5,
  parameter int MAX_COPIES = 4,
  parameter int COPY_W     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              per_valid,
  input  spacing_e          per_class,
  output logic              ld_valid,
  output logic [COPY_W-1:0] ld_count,
  output logic              ld_value
);
  localparam int QW = RUN_W + 1;
  localparam logic [QW-1:0]    DIVN    = QW'(DIV_NARROW);
  localparam logic [QW-1:0]    DIVW    = QW'(DIV_WIDE);
  localparam logic [QW-1:0]    QMAX    = QW'(MAX_COPIES);
  localparam logic [RUN_W-1:0] RUN_MAX = '1;
  localparam logic [RUN_W-1:0] RUN_ONE = RUN_W'(1);

  logic              open_q, open_d;
  spacing_e          cls_q, cls_d;
  logic [RUN_W-1:0]  n_q, n_d;
  logic [QW-1:0]     nplus, quot;
  logic              closing;

  assign nplus   = {1'b0, n_q} + QW'(1);
  assign quot    = (cls_q == SPC_NARROW) ? (nplus / DIVN) : (nplus / DIVW);
  assign closing = per_valid && open_q && (per_class != cls_q);

  always_comb begin
    open_d = open_q;
    cls_d  = cls_q;
    n_d    = n_q;
    if (per_valid) begin
      if (!open_q || (per_class != cls_q)) begin
        open_d = 1'b1;
        cls_d  = per_class;
        n_d    = RUN_ONE;
      end else if (n_q != RUN_MAX) begin
        n_d = n_q + RUN_ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      cls_q  <= SPC_WIDE;
      n_q    <= '0;
    end else begin
      open_q <= open_d;
      cls_q  <= cls_d;
      n_q    <= n_d;
    end
  end

  assign ld_valid = closing && (quot != '0) && (quot <= QMAX);
  assign ld_count = quot[COPY_W-1:0];
  assign ld_value = (cls_q == SPC_NARROW);

  // R9: an open run always holds a length of at least one
  assert_run_nonzero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    open_q |-> (n_q != '0));
  // R4: a same-class distance extends the run by exactly one below saturation
  assert_run_grow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (per_valid && open_q && (per_class == cls_q) && (n_q != RUN_MAX))
      |=> (n_q == $past(n_q) + RUN_ONE));
  // R4: a class change restarts the run at length one
  assert_run_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
    closing |=> (n_q == RUN_ONE));
endmodule

// File: rtl/fskd_halfbit_emitter.sv
module fskd_halfbit_emitter #(
  parameter int COPY_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_valid,
  input  logic [COPY_W-1:0] ld_count,
  input  logic              ld_value,
  output logic              hb_valid,
  output logic              hb_value
);
  localparam logic [COPY_W-1:0] ONE = COPY_W'(1);

  logic [COPY_W-1:0] left_q, left_d;
  logic              val_q, val_d;

  always_comb begin
    left_d = left_q;
    val_d  = val_q;
    if (ld_valid) begin
      left_d = ld_count;
      val_d  = ld_value;
    end else if (left_q != '0) begin
      left_d = left_q - ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q <= '0;
      val_q  <= 1'b0;
    end else begin
      left_q <= left_d;
      val_q  <= val_d;
    end
  end

  assign hb_valid = (left_q != '0);
  assign hb_value = val_q;

  // R6: a new burst never cuts short a burst still owing copies
  assert_no_loss_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |-> (left_q <= ONE));
  // R6: copies go out one per cycle
  assert_countdown_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((left_q != '0) && !ld_valid) |=> (left_q == $past(left_q) - ONE));
  // R6: the symbol stays fixed through a burst
  assert_value_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((left_q > ONE) && !ld_valid) |=> $stable(hb_value));
endmodule

// File: rtl/fskd_demod.sv
module fskd_demod
  import fskd_pkg::*;
#(
  parameter int SAMPLE_W     = 8,
  parameter int SLICE_LEVEL  = 127,
  parameter int PERIOD_W     = 8,
  parameter int NARROW_LIMIT = 9,
  parameter int RUN_W        = 8,
  parameter int DIV_NARROW   = 6,
  parameter int DIV_WIDE     = 5,
  parameter int MAX_COPIES   = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                smp_valid,
  input  logic [SAMPLE_W-1:0] smp_data,
  output logic                hb_valid,
  output logic                hb_value
);
  localparam int COPY_W = $clog2(MAX_COPIES + 1);

  logic [1:0]        rst_pipe_q;
  logic              rst_core_n;
  logic              per_valid;
  spacing_e          per_class;
  logic              ld_valid;
  logic [COPY_W-1:0] ld_count;
  logic              ld_value;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_core_n = rst_pipe_q[1];

  fskd_edge_timer #(
    .SAMPLE_W(SAMPLE_W), .SLICE_LEVEL(SLICE_LEVEL),
    .PERIOD_W(PERIOD_W), .NARROW_LIMIT(NARROW_LIMIT)
  ) u_timer (
    .clk(clk), .rst_n(rst_core_n),
    .smp_valid(smp_valid), .smp_data(smp_data),
    .per_valid(per_valid), .per_class(per_class)
  );

  fskd_run_grouper #(
    .RUN_W(RUN_W), .DIV_NARROW(DIV_NARROW), .DIV_WIDE(DIV_WIDE),
    .MAX_COPIES(MAX_COPIES), .COPY_W(COPY_W)
  ) u_group (
    .clk(clk), .rst_n(rst_core_n),
    .per_valid(per_valid), .per_class(per_class),
    .ld_valid(ld_valid), .ld_count(ld_count), .ld_value(ld_value)
  );

  fskd_halfbit_emitter #(.COPY_W(COPY_W)) u_emit (
    .clk(clk), .rst_n(rst_core_n),
    .ld_valid(ld_valid), .ld_count(ld_count), .ld_value(ld_value),
    .hb_valid(hb_valid), .hb_value(hb_value)
  );

  // R10: while reset is held the output strobe stays low
  assert_reset_quiet_R10: assert property (@(posedge clk)
    !rst_n |-> !hb_valid);
endmodule

// File: tb/fskd_demod_tb.sv
module fskd_demod_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       smp_valid = 1'b0;
  logic [7:0] smp_data = 8'd0;
  logic       hb_valid, hb_value;

  always #2.5 clk = ~clk;

  fskd_demod u_dut (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
    .hb_valid(hb_valid), .hb_value(hb_value)
  );

  int    cyc = 0;
  int    errors = 0;
  int    checks = 0;
  bit    finished = 0;
  string cur_tag = "R6";
  int    gap = 0;
  logic [7:0] hv = 8'd200;
  logic [7:0] lv = 8'd30;

  int    q_val[$];
  int    q_cyc[$];
  string q_tag[$];

  // model state, built from the requirements
  bit m_prev, m_have, m_sync, m_open, m_cls;
  int m_cnt, m_n;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic model_reset();
    m_prev = 0; m_have = 0; m_sync = 0; m_open = 0; m_cls = 0;
    m_cnt = 0; m_n = 0;
  endtask

  task automatic close_run(input bit cls, input int c);
    int worth;
    if (!m_open) begin
      m_open = 1; m_cls = cls; m_n = 1;
    end else if (cls == m_cls) begin
      if (m_n < 255) m_n++;
    end else begin
      worth = m_cls ? (m_n + 1) / 6 : (m_n + 1) / 5;   // R5
      if (worth >= 1 && worth <= 4) begin             // R6 R7
        for (int j = 0; j < worth; j++) begin
          q_val.push_back(int'(m_cls));
          q_cyc.push_back(c + 2 + j);                 // R8 timing
          q_tag.push_back(cur_tag);
        end
      end
      m_cls = cls; m_n = 1;
    end
  endtask

  task automatic model(input logic [7:0] v, input int c);
    bit b;
    b = (v >= 8'd127);                                // R1
    if (m_have && !m_prev && b) begin
      if (m_sync) close_run(m_cnt < 9, c);            // R3 split
      m_cnt = 1; m_sync = 1;                          // R2
    end else if (m_sync && m_cnt < 255) begin
      m_cnt++;                                        // R9
    end
    m_prev = b; m_have = 1;
  endtask

  task automatic put(input logic [7:0] v);
    for (int g = 0; g < gap; g++) begin
      @(negedge clk); smp_valid = 1'b0; smp_data = 8'hA5;
    end
    @(negedge clk); smp_valid = 1'b1; smp_data = v;
    model(v, cyc);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); smp_valid = 1'b0;
    end
  endtask

  task automatic pulse(input int hi, input int lo);
    for (int i = 0; i < hi; i++) put(hv);
    for (int i = 0; i < lo; i++) put(lv);
  endtask

  task automatic run_n(input int k);  repeat (k) pulse(2, 6); endtask
  task automatic run_w(input int k);  repeat (k) pulse(3, 7); endtask

  task automatic check_drained(input string tag);
    idle(12);
    checks++;
    if (q_val.size() != 0) begin
      errors++;
      $display("FAIL %s: pending symbols actual=%0d expected=0", tag, q_val.size());
      q_val.delete(); q_cyc.delete(); q_tag.delete();
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    int v, t;
    string g;
    if (rst_n && hb_valid && !finished) begin
      checks++;
      if (q_val.size() == 0) begin
        errors++;
        $display("FAIL %s: unexpected symbol actual=%0d expected=none (cycle %0d)",
                 cur_tag, hb_value, cyc);
      end else begin
        v = q_val.pop_front(); t = q_cyc.pop_front(); g = q_tag.pop_front();
        if (int'(hb_value) != v || cyc != t) begin
          errors++;
          $display("FAIL %s R8: actual value=%0d cycle=%0d expected value=%0d cycle=%0d",
                   g, hb_value, cyc, v, t);
        end
      end
    end
  end

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; smp_valid = 1'b0;
    model_reset();
    repeat (3) begin
      @(negedge clk);
      checks++;
      if (hb_valid !== 1'b0) begin
        errors++;
        $display("FAIL R10: hb_valid in reset actual=%b expected=0", hb_valid);
      end
    end
    rst_n = 1'b1;
    idle(5);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++; checks++;
      $display("FAIL R6: watchdog expired actual=running expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    model_reset();
    do_reset();                                   // R10 reset state

    // R2: high start with no prior low, then a short settle, then a frame
    cur_tag = "R2";
    repeat (10) put(hv);
    run_n(3);
    check_drained("R2");

    // R4 R5 R6 R7: runs of many lengths in both classes
    cur_tag = "R5";
    run_w(3);
    run_n(6);  run_w(5);  run_n(12); run_w(10);
    run_n(17); run_w(14); run_n(23); run_w(19);
    run_n(5);  run_w(4);  run_n(4);  run_w(3);
    run_n(29); run_w(24); run_n(11); run_w(9);
    run_n(3);
    check_drained("R5");

    // R1: slicing right at the threshold
    cur_tag = "R1";
    hv = 8'd127; lv = 8'd126;
    run_n(12); run_w(10); run_n(6); run_w(5);
    hv = 8'd126; lv = 8'd30;
    pulse(3, 5);                                  // 126 stays low: no crossing
    hv = 8'd200;
    run_n(6); run_w(3);
    check_drained("R1");

    // R3: split between 8 and 9 samples
    cur_tag = "R3";
    repeat (12) pulse(4, 4);
    repeat (10) pulse(4, 5);
    repeat (12) pulse(4, 4);
    pulse(3, 7);
    check_drained("R3");

    // R3: gaps in the sample strobe are not counted
    cur_tag = "R3";
    gap = 2;
    run_n(12); run_w(10); run_n(6); run_w(2);
    gap = 0;
    check_drained("R3");

    // R9: saturated run worth too much, saturated gap classed wide
    cur_tag = "R9";
    run_n(300); run_w(10);
    repeat (400) put(lv);
    run_w(9); run_n(12); run_w(2);
    check_drained("R9");

    // R10: reset mid-run, state must not carry over
    cur_tag = "R10";
    run_n(12); run_w(3);
    idle(8);
    do_reset();
    run_w(3); run_n(12); run_w(10); run_n(2);
    check_drained("R10");

    // R6 R8: back-to-back bursts in opposite classes
    cur_tag = "R6";
    run_n(23); run_w(19); run_n(23); run_w(2);
    check_drained("R6");

    finished = 1;
    summary();
    $finish;
  end
endmodule